// File: doc/BRIEF.md
# Target Address Phase Sequencer

When a target transaction has been accepted on the host side, this block passes its start address to the user application over a narrow port. It sends only the address bits that the decoded base-address window covers, one word at a time, and marks the last word. The port runs in one of two widths. A narrow 16-bit mode carries the flags in bits 16 and 17 of the word. A wide 32-bit mode carries the flags on a separate two-bit side bus.

A one-cycle `txn_valid` pulse loads the transaction while the block is idle. The block then pulls its active-low request low and presents the command code and the window index on their own buses. It waits for the application to move each word. A word moves on a clock edge where `app_ready` is high and `app_en_n` is low while the request is active. After the final word the request returns high and the block is idle again.

The number of address bits is given per transaction as `txn_span`. Examples: a 256 KiB window has a span of 18, which gives one word in wide mode and two words in narrow mode.

Top module: `tgt_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released with no transaction, `req_n` and `last_n` are both 1.
- R2: A `txn_valid` pulse sampled while idle makes `req_n` go to 0 on the next cycle. `cmd_out` and `bar_out` then show the loaded command and window index, and they stay unchanged for as long as `req_n` is 0.
- R3: A word is consumed only at a clock edge where `req_n`=0, `app_ready`=1 and `app_en_n`=0. At any other edge, `word_out`, `side_out` and `last_n` hold their values.
- R4: The word count is ceil(span/W), where W is 16 in narrow mode (`mode_wide`=0) and 32 in wide mode (`mode_wide`=1). A span of 0 is treated as 1, and a span above 32 is treated as 32.
- R5: Words are sent least-significant first. Word k carries address bits [k*W+W-1 : k*W]. Address bits at or above the span read as 0.
- R6: In narrow mode, `word_out[15:0]` is the address chunk, bit 16 is the dual-address flag, bit 17 is the burst flag, bits 31:18 are 0, and `side_out` is 0.
- R7: In wide mode, `word_out` is the full 32-bit chunk, `side_out[0]` is the dual-address flag and `side_out[1]` is the burst flag.
- R8: `last_n` is 0 exactly while the final word of the transaction is presented, and never while `req_n` is 1.
- R9: The cycle after the final word is consumed, `req_n` is 1. A `txn_valid` pulse that arrives while a transaction is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wide | input | 1 | 1 = 32-bit port, 0 = 16-bit port (loaded with the transaction) |
| txn_valid | input | 1 | Accepted-transaction pulse |
| txn_addr | input | 32 | Transaction start address |
| txn_cmd | input | 4 | Bus command code |
| txn_bar | input | 3 | Decoded window index |
| txn_span | input | 6 | Number of address bits covered by the decoded window |
| txn_dac | input | 1 | Dual-address cycle flag |
| txn_burst | input | 1 | Burst flag |
| app_ready | input | 1 | Application ready |
| app_en_n | input | 1 | Application active-low address enable |
| req_n | output | 1 | Active-low request to the application |
| cmd_out | output | 4 | Command of the current transaction |
| bar_out | output | 3 | Window index of the current transaction |
| word_out | output | 32 | Address word (narrow mode: flags in bits 16 and 17) |
| side_out | output | 2 | Wide-mode flag bits {burst, dual-address} |
| last_n | output | 1 | Active-low final-word strobe |

## Verification
Transactions cover both port widths. In narrow mode the spans are 4, 16, 18 and 32: 16 and 18 sit on either side of the one-word/two-word boundary, and 4 shows that high address bits are masked. In wide mode the spans are 18 and 32, which shows that the word count stays at one. The flag combinations differ from one transaction to the next, so a swapped or misplaced dual-address or burst bit shows up as a difference.

The handshake pattern mixes cycles with ready low, enable high and both active. A word that advances without a full handshake is therefore caught. A stray `txn_valid` pulse with different fields arrives during each transfer, which shows whether the loaded transaction is protected while the block is busy.

// File: rtl/tgt_addr_seq_pkg.sv
package tgt_addr_seq_pkg;
  typedef enum logic [0:0] {
    SQ_IDLE = 1'b0,
    SQ_SEND = 1'b1
  } sq_state_e;
endpackage

// File: rtl/tgt_span_decode.sv
module tgt_span_decode #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int SPAN_W   = 6,
  parameter int CNT_W    = 2
) (
  input  logic [SPAN_W-1:0] span,
  input  logic              wide,
  output logic [ADDR_W-1:0] mask,
  output logic [CNT_W-1:0]  nwords
);
  localparam int EXT_W = SPAN_W + 2;

  logic [EXT_W-1:0] span_eff;
  logic [EXT_W-1:0] cnt_narrow;
  logic [EXT_W-1:0] cnt_wide;

  always_comb begin
    if (span == '0) begin
      span_eff = EXT_W'(1);
    end else if (EXT_W'(span) > EXT_W'(ADDR_W)) begin
      span_eff = EXT_W'(ADDR_W);
    end else begin
      span_eff = EXT_W'(span);
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < ADDR_W; gi++) begin : g_mask
      assign mask[gi] = (EXT_W'(gi) < span_eff);
    end
  endgenerate

  always_comb begin
    cnt_narrow = (span_eff + EXT_W'(NARROW_W - 1)) / EXT_W'(NARROW_W);
    cnt_wide   = (span_eff + EXT_W'(WIDE_W - 1)) / EXT_W'(WIDE_W);
    nwords     = wide ? CNT_W'(cnt_wide) : CNT_W'(cnt_narrow);
  end
endmodule

// File: rtl/tgt_word_format.sv
module tgt_word_format #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int CNT_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  idx,
  input  logic              wide,
  input  logic              dac,
  input  logic              burst,
  output logic [WIDE_W-1:0] word,
  output logic [1:0]        side
);
  logic [ADDR_W-1:0]   narrow_sh;
  logic [ADDR_W-1:0]   wide_sh;
  logic [NARROW_W-1:0] narrow_chunk;
  logic [WIDE_W-1:0]   wide_chunk;

  always_comb begin
    narrow_sh    = addr >> (32'(idx) * NARROW_W);
    wide_sh      = addr >> (32'(idx) * WIDE_W);
    narrow_chunk = narrow_sh[NARROW_W-1:0];
    wide_chunk   = WIDE_W'(wide_sh);
    if (wide) begin
      word = wide_chunk;
      side = {burst, dac};
    end else begin
      word = '0;
      word[NARROW_W-1:0] = narrow_chunk;
      word[NARROW_W]     = dac;
      word[NARROW_W+1]   = burst;
      side = 2'b00;
    end
  end
endmodule

// File: rtl/tgt_addr_seq.sv
module tgt_addr_seq #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int CMD_W    = 4,
  parameter int BAR_W    = 3,
  parameter int SPAN_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide,
  input  logic              txn_valid,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [CMD_W-1:0]  txn_cmd,
  input  logic [BAR_W-1:0]  txn_bar,
  input  logic [SPAN_W-1:0] txn_span,
  input  logic              txn_dac,
  input  logic              txn_burst,
  input  logic              app_ready,
  input  logic              app_en_n,
  output logic              req_n,
  output logic [CMD_W-1:0]  cmd_out,
  output logic [BAR_W-1:0]  bar_out,
  output logic [WIDE_W-1:0] word_out,
  output logic [1:0]        side_out,
  output logic              last_n
);
  import tgt_addr_seq_pkg::*;

  localparam int MAX_WORDS = (ADDR_W + NARROW_W - 1) / NARROW_W;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);

  sq_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [BAR_W-1:0]  bar_q;
  logic              dac_q, burst_q, wide_q;
  logic [CNT_W-1:0]  nw_q, idx_q, idx_d;
  logic [ADDR_W-1:0] dec_mask;
  logic [CNT_W-1:0]  dec_nw;
  logic              load, fire, final_word;

  tgt_span_decode #(
    .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W),
    .SPAN_W(SPAN_W), .CNT_W(CNT_W)
  ) u_decode (
    .span(txn_span), .wide(mode_wide), .mask(dec_mask), .nwords(dec_nw)
  );

  tgt_word_format #(
    .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .CNT_W(CNT_W)
  ) u_format (
    .addr(addr_q), .idx(idx_q), .wide(wide_q), .dac(dac_q),
    .burst(burst_q), .word(word_out), .side(side_out)
  );

  always_comb begin
    load       = (state_q == SQ_IDLE) && txn_valid;
    final_word = (state_q == SQ_SEND) && (idx_q == nw_q - CNT_W'(1));
    fire       = (state_q == SQ_SEND) && app_ready && !app_en_n;
    state_d    = state_q;
    idx_d      = idx_q;
    if (load) begin
      state_d = SQ_SEND;
      idx_d   = '0;
    end else if (fire) begin
      if (final_word) begin
        state_d = SQ_IDLE;
        idx_d   = '0;
      end else begin
        idx_d = idx_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cmd_q   <= '0;
      bar_q   <= '0;
      dac_q   <= 1'b0;
      burst_q <= 1'b0;
      wide_q  <= 1'b0;
      nw_q    <= CNT_W'(1);
    end else if (load) begin
      addr_q  <= txn_addr & dec_mask;
      cmd_q   <= txn_cmd;
      bar_q   <= txn_bar;
      dac_q   <= txn_dac;
      burst_q <= txn_burst;
      wide_q  <= mode_wide;
      nw_q    <= dec_nw;
    end
  end

  assign req_n   = (state_q != SQ_SEND);
  assign last_n  = !final_word;
  assign cmd_out = cmd_q;
  assign bar_out = bar_q;

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_n && txn_valid) |=> !req_n);
  p_ctx_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && !(app_ready && !app_en_n && !last_n)) |=>
      (!req_n && $stable(cmd_out) && $stable(bar_out)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && !(app_ready && !app_en_n)) |=>
      ($stable(word_out) && $stable(side_out) && $stable(last_n)));
  p_last_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !last_n |-> !req_n);
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && !last_n && app_ready && !app_en_n) |=> req_n);
  p_side_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && !wide_q) |-> (side_out == 2'b00 && word_out[WIDE_W-1:NARROW_W+2] == '0));
endmodule

// File: tb/tgt_addr_seq_tb_top.sv
module tgt_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_wide, txn_valid, txn_dac, txn_burst, app_ready, app_en_n;
  logic [31:0] txn_addr;
  logic [3:0]  txn_cmd;
  logic [2:0]  txn_bar;
  logic [5:0]  txn_span;
  logic        req_n, last_n;
  logic [3:0]  cmd_out;
  logic [2:0]  bar_out;
  logic [31:0] word_out;
  logic [1:0]  side_out;

  int checks = 0;
  int fails  = 0;
  logic [41:0] exp_q[$];
  logic expect_idle = 1'b0;
  logic mon_on = 1'b0;

  always #2.5 clk = ~clk;

  tgt_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .txn_valid(txn_valid),
    .txn_addr(txn_addr), .txn_cmd(txn_cmd), .txn_bar(txn_bar),
    .txn_span(txn_span), .txn_dac(txn_dac), .txn_burst(txn_burst),
    .app_ready(app_ready), .app_en_n(app_en_n), .req_n(req_n),
    .cmd_out(cmd_out), .bar_out(bar_out), .word_out(word_out),
    .side_out(side_out), .last_n(last_n)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Scoreboard monitor: R3 R5 R6 R7 R8 R2 R9
  always @(negedge clk) begin
    if (mon_on) begin
      if (expect_idle) begin
        check(req_n == 1'b1, "R9 req released after final word", 64'(req_n), 64'd1);
        expect_idle = 1'b0;
      end
      if (!req_n) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected extra word", 64'(word_out), 64'd0);
        end else begin
          logic [41:0] e;
          e = exp_q[0];
          check({word_out, side_out} == e[41:8], "R5/R6/R7 word content",
                64'({word_out, side_out}), 64'(e[41:8]));
          check(last_n == e[7], "R8 last strobe", 64'(last_n), 64'(e[7]));
          check({cmd_out, bar_out} == e[6:0], "R2 command and window",
                64'({cmd_out, bar_out}), 64'(e[6:0]));
          if (app_ready && !app_en_n) begin
            void'(exp_q.pop_front());
            if (!e[7]) expect_idle = 1'b1;
          end
        end
      end else begin
        check(last_n == 1'b1, "R8 last inactive while idle", 64'(last_n), 64'd1);
      end
    end
  end

  task automatic run_txn(input logic wide, input logic [31:0] a, input logic [5:0] span,
                         input logic dac, input logic burst, input logic [3:0] cmd,
                         input logic [2:0] bar, input int pat);
    int eff, w, nw;
    logic [31:0] m, am;
    eff = (span == 0) ? 1 : ((span > 32) ? 32 : int'(span));
    w   = wide ? 32 : 16;
    nw  = (eff + w - 1) / w;
    m   = (eff >= 32) ? 32'hFFFF_FFFF : ((32'd1 << eff) - 32'd1);
    am  = a & m;
    for (int k = 0; k < nw; k++) begin
      logic [31:0] wd;
      logic [1:0]  sd;
      if (wide) begin
        wd = am;
        sd = {burst, dac};
      end else begin
        wd = {14'd0, burst, dac, am[k*16 +: 16]};
        sd = 2'b00;
      end
      exp_q.push_back({wd, sd, (k != nw - 1), cmd, bar});
    end
    @(posedge clk); #1;
    mode_wide = wide; txn_addr = a; txn_span = span; txn_dac = dac;
    txn_burst = burst; txn_cmd = cmd; txn_bar = bar; txn_valid = 1'b1;
    app_ready = 1'b0; app_en_n = 1'b1;
    @(posedge clk); #1;
    // R9: stray pulse with other fields while busy must be ignored
    txn_valid = 1'b1; txn_addr = ~a; txn_cmd = ~cmd; txn_bar = ~bar;
    txn_dac = ~dac; txn_burst = ~burst; txn_span = 6'd32; mode_wide = ~wide;
    for (int k = 0; k < 64; k++) begin
      app_ready = ((k + pat) % 3) != 1;
      app_en_n  = ((k + pat) % 4) == 2;
      @(posedge clk); #1;
      txn_valid = 1'b0;
      if (req_n) break;
    end
    app_ready = 1'b0; app_en_n = 1'b1;
    @(posedge clk); #1;
    check(exp_q.size() == 0, "R4 word count consumed", 64'(exp_q.size()), 64'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; txn_valid = 1'b0; mode_wide = 1'b0; txn_addr = '0;
    txn_cmd = '0; txn_bar = '0; txn_span = '0; txn_dac = 1'b0;
    txn_burst = 1'b0; app_ready = 1'b0; app_en_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_n == 1'b1 && last_n == 1'b1, "R1 reset outputs", 64'({req_n, last_n}), 64'd3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_n == 1'b1 && last_n == 1'b1, "R1 idle after reset", 64'({req_n, last_n}), 64'd3);
    mon_on = 1'b1;
    run_txn(1'b0, 32'hABCD_1234, 6'd18, 1'b0, 1'b1, 4'h6, 3'd1, 0);
    run_txn(1'b1, 32'hABCD_1234, 6'd18, 1'b1, 1'b0, 4'h7, 3'd2, 1);
    run_txn(1'b0, 32'h5A5A_F00F, 6'd16, 1'b1, 1'b0, 4'h2, 3'd0, 2);
    run_txn(1'b0, 32'h8765_4321, 6'd32, 1'b1, 1'b1, 4'hC, 3'd5, 3);
    run_txn(1'b1, 32'hDEAD_BEEF, 6'd32, 1'b0, 1'b1, 4'hE, 3'd4, 0);
    run_txn(1'b0, 32'hFFFF_FFFF, 6'd4,  1'b0, 1'b0, 4'h3, 3'd3, 1);
    run_txn(1'b0, 32'h0001_FFFF, 6'd0,  1'b1, 1'b1, 4'hA, 3'd6, 2);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule